// File: doc/BRIEF.md
# Karatsuba Ternary Polynomial Digit Multiplier

This block multiplies two polynomials over GF(3). Each operand has `DIGITS` coefficients (trits). The block returns the full product of `2*DIGITS-1` trits and does no modular reduction. It is the digit-by-digit multiplier that sits inside a digit-serial extension-field multiplier. That outer multiplier owns the reduction and the sequencing. This block only forms the plain polynomial product.

The product is built by recursive two-way splitting. Each operand is cut into a low half of `ceil(N/2)` trits and a high half of `floor(N/2)` trits. The shorter half is zero-extended. Three half-size products are formed: low·low, high·high and (low+high)·(low+high). They are recombined at trit offsets 0, h and 2h, where h is the size of the low half. The middle term is the sum product minus the other two, taken modulo 3. `KLEVELS` sets how many splitting levels run before the leaves fall back to a schoolbook array. Examples are one level over a classical leaf, or two levels over a classical leaf, which suits `DIGITS=7`. The combinational product is captured in one output register.

Top module: `ktm_mult`

## Requirements
- R1: `p_o` equals the GF(3) polynomial product of `a_i` and `b_i`, with all `2*DIGITS-1` coefficients kept and no reduction.
- R2: Trit k of a bus sits at bits [2k+1:2k]. The value 0 is coded 00, 1 is coded 01 and 2 is coded 10.
- R3: The code 11 on any input trit is taken as the value 0.
- R4: No trit of `p_o` ever carries the code 11.
- R5: `p_o` has one cycle of latency. The product of the inputs sampled at a rising edge appears just after that edge. Between edges, `p_o` holds the previous result while the inputs change.
- R6: Driving `rst_ni` low clears `p_o` to all zeros at once, without waiting for a clock edge.
- R7: An all-zero operand gives an all-zero product on the next cycle.
- R8: When `b_i` is the constant polynomial 1 (trit 0 = 01, all others 00), the next output equals `a_i` zero-extended, with 11 codes turned into 00.
- R9: Trit 0 of the result is a0·b0. Trit 2·DIGITS-2 is a(D-1)·b(D-1).
- R10: Any `KLEVELS` value from 0 (pure schoolbook) upward gives the same product. This holds for odd sizes too, where the split is ceil/floor.
- R11: `DIGITS` may be as small as 1. Recursion stops at one-trit operands, whatever `KLEVELS` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 2*DIGITS | Operand A, 2-bit trit coding |
| b_i | input | 2*DIGITS | Operand B, 2-bit trit coding |
| p_o | output | 2*(2*DIGITS-1) | Registered product, 2-bit trit coding |

## Verification
On every cycle, the assertions check four things: output trits stay legal, a zero operand gives a zero result, a unit operand gives the identity, and the two extreme result trits match single-trit products. Full product equality over all middle trits can only be shown by the bench scenarios. So can equivalence across recursion schedules and odd splits, the handling of 11 input codes and the asynchronous clear. For these the bench runs several sizes and schedules side by side against a behavioural schoolbook model. It also checks that the output holds between edges.

// File: rtl/ktm_pkg.sv
package ktm_pkg;
  typedef logic [1:0] trit_t;

  localparam trit_t TRIT_0 = 2'b00;
  localparam trit_t TRIT_1 = 2'b01;
  localparam trit_t TRIT_2 = 2'b10;

  function automatic trit_t gf3_clean(trit_t x);
    return (x == 2'b11) ? TRIT_0 : x;
  endfunction

  function automatic trit_t gf3_add(trit_t x, trit_t y);
    trit_t cx, cy;
    cx = gf3_clean(x);
    cy = gf3_clean(y);
    if (cx == TRIT_0) return cy;
    if (cy == TRIT_0) return cx;
    if (cx == cy) return (cx == TRIT_1) ? TRIT_2 : TRIT_1;
    return TRIT_0;
  endfunction

  function automatic trit_t gf3_neg(trit_t x);
    trit_t cx;
    cx = gf3_clean(x);
    return {cx[0], cx[1]};
  endfunction

  function automatic trit_t gf3_sub(trit_t x, trit_t y);
    return gf3_add(x, gf3_neg(y));
  endfunction

  function automatic trit_t gf3_mul(trit_t x, trit_t y);
    trit_t cx, cy;
    cx = gf3_clean(x);
    cy = gf3_clean(y);
    if (cx == TRIT_0 || cy == TRIT_0) return TRIT_0;
    return (cx == cy) ? TRIT_1 : TRIT_2;
  endfunction
endpackage

// File: rtl/ktm_school.sv
module ktm_school
  import ktm_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [2*N-1:0]       a_i,
  input  logic [2*N-1:0]       b_i,
  output logic [2*(2*N-1)-1:0] p_o
);
  localparam int PT = 2*N-1;

  always_comb begin
    p_o = '0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        p_o[2*(i+j) +: 2] = gf3_add(p_o[2*(i+j) +: 2],
                                    gf3_mul(a_i[2*i +: 2], b_i[2*j +: 2]));
      end
    end
  end

  logic unused_pt;
  assign unused_pt = (PT == 0);
endmodule

// File: rtl/ktm_kara.sv
module ktm_kara
  import ktm_pkg::*;
#(
  parameter int N      = 7,
  parameter int LEVELS = 2
) (
  input  logic [2*N-1:0]       a_i,
  input  logic [2*N-1:0]       b_i,
  output logic [2*(2*N-1)-1:0] p_o
);
  localparam int H  = (N + 1) / 2;   // low half, ceil
  localparam int L  = N - H;         // high half, floor
  localparam int SW = 2*(2*H-1);     // sub-product width
  localparam int WW = 2*(4*H-1);     // combine width, >= output width
  localparam int PW = 2*(2*N-1);

  if (LEVELS == 0 || N < 2) begin : g_leaf
    ktm_school #(.N(N)) u_school (
      .a_i(a_i),
      .b_i(b_i),
      .p_o(p_o)
    );
  end else begin : g_split
    logic [2*H-1:0] a_lo, a_hi, a_sum;
    logic [2*H-1:0] b_lo, b_hi, b_sum;
    logic [SW-1:0]  p_lo, p_hi, p_mid;
    logic [WW-1:0]  acc;

    always_comb begin
      a_lo = a_i[2*H-1:0];
      b_lo = b_i[2*H-1:0];
      a_hi = '0;
      b_hi = '0;
      a_hi[2*L-1:0] = a_i[2*N-1:2*H];
      b_hi[2*L-1:0] = b_i[2*N-1:2*H];
      for (int k = 0; k < H; k++) begin
        a_sum[2*k +: 2] = gf3_add(a_lo[2*k +: 2], a_hi[2*k +: 2]);
        b_sum[2*k +: 2] = gf3_add(b_lo[2*k +: 2], b_hi[2*k +: 2]);
      end
    end

    ktm_kara #(.N(H), .LEVELS(LEVELS-1)) u_lo (
      .a_i(a_lo), .b_i(b_lo), .p_o(p_lo)
    );
    ktm_kara #(.N(H), .LEVELS(LEVELS-1)) u_hi (
      .a_i(a_hi), .b_i(b_hi), .p_o(p_hi)
    );
    ktm_kara #(.N(H), .LEVELS(LEVELS-1)) u_mid (
      .a_i(a_sum), .b_i(b_sum), .p_o(p_mid)
    );

    // recombine at offsets 0, H, 2H; trits past 2N-2 are zero by algebra
    always_comb begin
      trit_t mid_t;
      acc = '0;
      for (int k = 0; k < 2*H-1; k++) begin
        mid_t = gf3_sub(gf3_sub(p_mid[2*k +: 2], p_lo[2*k +: 2]), p_hi[2*k +: 2]);
        acc[2*k +: 2]       = gf3_add(acc[2*k +: 2], p_lo[2*k +: 2]);
        acc[2*(k+H) +: 2]   = gf3_add(acc[2*(k+H) +: 2], mid_t);
        acc[2*(k+2*H) +: 2] = gf3_add(acc[2*(k+2*H) +: 2], p_hi[2*k +: 2]);
      end
    end

    assign p_o = acc[PW-1:0];

    logic unused_acc;
    assign unused_acc = ^acc;
  end
endmodule

// File: rtl/ktm_mult.sv
module ktm_mult
  import ktm_pkg::*;
#(
  parameter int DIGITS  = 7,
  parameter int KLEVELS = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [2*DIGITS-1:0]       a_i,
  input  logic [2*DIGITS-1:0]       b_i,
  output logic [2*(2*DIGITS-1)-1:0] p_o
);
  localparam int AW = 2*DIGITS;
  localparam int PT = 2*DIGITS-1;
  localparam int PW = 2*PT;
  localparam logic [AW-1:0] UNIT = AW'(1);

  logic [PW-1:0] prod;

  ktm_kara #(.N(DIGITS), .LEVELS(KLEVELS)) u_core (
    .a_i(a_i),
    .b_i(b_i),
    .p_o(prod)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) p_o <= '0;
    else         p_o <= prod;
  end

  // assertion helper: operand A with illegal codes mapped to zero
  logic [AW-1:0] a_clean;
  for (genvar k = 0; k < DIGITS; k++) begin : g_clean
    assign a_clean[2*k +: 2] = gf3_clean(a_i[2*k +: 2]);
  end

  for (genvar k = 0; k < PT; k++) begin : g_legal
    p_legal_code_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      p_o[2*k +: 2] != 2'b11);
  end

  p_zero_operand_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i == '0 || b_i == '0) |=> p_o == '0);

  p_unit_identity_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_i == UNIT) |=> p_o == PW'($past(a_clean)));

  p_low_trit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> p_o[1:0] == gf3_mul($past(a_i[1:0]), $past(b_i[1:0])));

  p_high_trit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> p_o[PW-1 -: 2] == gf3_mul($past(a_i[AW-1 -: 2]), $past(b_i[AW-1 -: 2])));
endmodule

// File: tb/test_ktm_mult.sv
`timescale 1ns/1ps
module test_ktm_mult;
  localparam int MAXD = 8;
  localparam int PW   = 2*(2*MAXD-1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2*MAXD-1:0] a = '0, b = '0;

  logic [25:0] p7k2, p7k1, p7k0;
  logic [29:0] p8k3;
  logic [17:0] p5k2;
  logic [1:0]  p1k1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit armed = 1'b0;
  string cur_tag = "";
  logic [PW-1:0] e7k2, e7k1, e7k0, e8k3, e5k2, e1k1;

  always #2.5 clk = ~clk;

  ktm_mult #(.DIGITS(7), .KLEVELS(2)) i_ktm_mult (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a[13:0]), .b_i(b[13:0]), .p_o(p7k2));
  ktm_mult #(.DIGITS(7), .KLEVELS(1)) i_ktm_mult_d7k1 (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a[13:0]), .b_i(b[13:0]), .p_o(p7k1));
  ktm_mult #(.DIGITS(7), .KLEVELS(0)) i_ktm_mult_d7k0 (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a[13:0]), .b_i(b[13:0]), .p_o(p7k0));
  ktm_mult #(.DIGITS(8), .KLEVELS(3)) i_ktm_mult_d8k3 (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a[15:0]), .b_i(b[15:0]), .p_o(p8k3));
  ktm_mult #(.DIGITS(5), .KLEVELS(2)) i_ktm_mult_d5k2 (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a[9:0]), .b_i(b[9:0]), .p_o(p5k2));
  ktm_mult #(.DIGITS(1), .KLEVELS(1)) i_ktm_mult_d1k1 (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a[1:0]), .b_i(b[1:0]), .p_o(p1k1));

  function automatic int tval(logic [1:0] c);
    if (c == 2'b01) return 1;
    if (c == 2'b10) return 2;
    return 0;  // R3: 11 counts as zero
  endfunction

  function automatic logic [PW-1:0] ref_mul(logic [2*MAXD-1:0] x, logic [2*MAXD-1:0] y, int n);
    int c[2*MAXD-1];
    logic [PW-1:0] r;
    for (int k = 0; k < 2*MAXD-1; k++) c[k] = 0;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < n; j++)
        c[i+j] += tval(x[2*i +: 2]) * tval(y[2*j +: 2]);
    r = '0;
    for (int k = 0; k < 2*n-1; k++) begin
      if (c[k] % 3 == 1) r[2*k +: 2] = 2'b01;
      else if (c[k] % 3 == 2) r[2*k +: 2] = 2'b10;
    end
    return r;
  endfunction

  function automatic logic [2*MAXD-1:0] rand_vec(bit allow_bad);
    logic [2*MAXD-1:0] v;
    for (int k = 0; k < MAXD; k++) begin
      int r = $urandom % 3;
      v[2*k +: 2] = (r == 0) ? 2'b00 : (r == 1) ? 2'b01 : 2'b10;
      if (allow_bad && ($urandom % 6 == 0)) v[2*k +: 2] = 2'b11;
    end
    return v;
  endfunction

  task automatic cmp(logic [PW-1:0] got, logic [PW-1:0] exp, string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic compare_all(string tag);
    cmp(PW'(p7k2), e7k2, {tag, " R1 d7k2"});
    cmp(PW'(p7k1), e7k1, {tag, " R10 d7k1"});
    cmp(PW'(p7k0), e7k0, {tag, " R10 d7k0"});
    cmp(PW'(p8k3), e8k3, {tag, " R10 d8k3"});
    cmp(PW'(p5k2), e5k2, {tag, " R10 d5k2"});
    cmp(PW'(p1k1), e1k1, {tag, " R11 d1k1"});
  endtask

  // drive at the falling edge; previous inputs were registered at the rising edge before it
  task automatic apply(logic [2*MAXD-1:0] na, logic [2*MAXD-1:0] nb, string tag);
    @(negedge clk);
    if (armed) compare_all(cur_tag);
    a = na;
    b = nb;
    #1;
    if (armed) compare_all("R5 hold");
    e7k2 = ref_mul(na, nb, 7);
    e7k1 = e7k2;
    e7k0 = e7k2;
    e8k3 = ref_mul(na, nb, 8);
    e5k2 = ref_mul(na, nb, 5);
    e1k1 = ref_mul(na, nb, 1);
    cur_tag = tag;
    armed = 1'b1;
  endtask

  task automatic check_zero_all(string tag);
    cmp(PW'(p7k2), '0, tag);
    cmp(PW'(p8k3), '0, tag);
    cmp(PW'(p5k2), '0, tag);
    cmp(PW'(p1k1), '0, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_zero_all("R6 reset state");
    rst_ni = 1'b1;

    // R7 zero operands
    apply('0, rand_vec(0), "R7 zero a");
    apply(rand_vec(0), '0, "R7 zero b");
    // R8 unit operand
    for (int i = 0; i < 8; i++) apply(rand_vec(i > 3), 16'h0001, "R8 unit b");
    // R2 coding: 2*2 = 1 in trit 0, 2*1 = 2
    apply(16'h0002, 16'h0002, "R2 code 2x2");
    apply(16'h0002, 16'h0001, "R2 code 2x1");
    // R9 extreme trits only
    apply(16'h8002, 16'h4001, "R9 extremes");
    apply(16'h2002, 16'h2002, "R9 d7 top");
    // dense patterns
    apply(16'h5555, 16'h5555, "R1 all ones");
    apply(16'haaaa, 16'haaaa, "R1 all twos");
    apply(16'h5555, 16'haaaa, "R1 ones x twos");
    // R3 illegal codes
    apply(16'hffff, rand_vec(0), "R3 all 11");
    for (int i = 0; i < 300; i++) apply(rand_vec(1), rand_vec(1), "R3 mixed 11");
    // R10/R11 random legal sweep
    for (int i = 0; i < 1500; i++) apply(rand_vec(0), rand_vec(0), "R1 random");

    // R6 async clear mid-run
    apply(16'h5555, 16'h5555, "R6 prefill");
    @(negedge clk);
    compare_all(cur_tag);
    armed = 1'b0;
    #1 rst_ni = 1'b0;
    #0.5;
    check_zero_all("R6 async clear");
    @(negedge clk);
    rst_ni = 1'b1;
    apply(rand_vec(0), rand_vec(0), "R1 after reset");
    apply('0, '0, "R7 flush");
    @(negedge clk);
    compare_all(cur_tag);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule